// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns one parallel character at a time into an asynchronous serial frame on a single line. A character is written into a holding register. When the shift stage is idle, the next baud tick moves the character into the shift stage. The frame then goes out as follows: one low start bit, the data bits least significant first, an optional parity bit, and a high stop period. The line rests high between frames.

The frame shape comes from a five-bit line-control input, which is captured at the moment a character enters the shift stage. This input sets the character length (5 to 8 bits), whether a parity bit is sent, whether that parity is even or odd, and whether the stop period is extended. An extended stop period lasts one and a half bit times for 5-bit characters and two bit times for longer ones.

Bit timing comes from a baud enable that pulses sixteen times per bit, so every bit lasts sixteen pulses. Two flags report occupancy: one shows that the holding register is free for a new character, and the other shows that the shift stage has finished its frame.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset `txd` is 1, `hold_empty` is 1 and `shift_empty` is 1, and `txd` stays 1 whenever `shift_empty` is 1.
- R2: A `hold_wr` pulse clears `hold_empty` at that clock edge. On the first baud tick that finds the shift stage empty and the holding register full, the character moves into the shift stage: `hold_empty` is set and `shift_empty` is cleared at that edge.
- R3: A frame starts with `txd` low for 16 baud ticks, beginning at the edge of the loading tick.
- R4: `line_ctrl[1:0]` selects the character length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. The data bits follow the start bit least significant bit first, 16 ticks each, and data bits above the selected length are not sent.
- R5: With `line_ctrl[3]` = 1, one parity bit of 16 ticks follows the last data bit and comes before the stop period. With `line_ctrl[3]` = 0, no parity slot is sent.
- R6: With `line_ctrl[4]` = 1, the sent data bits plus the parity bit contain an even number of ones. With `line_ctrl[4]` = 0, they contain an odd number. `line_ctrl[4]` has no effect when `line_ctrl[3]` = 0.
- R7: With `line_ctrl[2]` = 0, the stop period is high for 16 ticks.
- R8: With `line_ctrl[2]` = 1 and a 5-bit length, the stop period is high for 24 ticks.
- R9: With `line_ctrl[2]` = 1 and a 6-, 7- or 8-bit length, the stop period is high for 32 ticks.
- R10: `shift_empty` is set on the tick that ends the stop period. A waiting character is loaded on the next tick, never on that same tick.
- R11: `line_ctrl` is sampled only when a character is loaded. Changing it during a frame does not alter that frame.
- R12: `txd` and `shift_empty` change only at a clock edge where `baud_x16` is high. `hold_empty` changes only on such an edge or on a `hold_wr` edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_x16 | input | 1 | One-cycle enable, sixteen per bit time |
| hold_wr | input | 1 | Write strobe for the holding register |
| hold_data | input | DATA_W | Character to be sent |
| line_ctrl | input | 5 | Frame format: [1:0] length, [2] long stop, [3] parity on, [4] even parity |
| txd | output | 1 | Serial output line, idles high |
| hold_empty | output | 1 | Holding register can accept a character |
| shift_empty | output | 1 | Shift stage idle, no frame in progress |

## Verification
The assertions assume that `hold_wr` is a single-cycle strobe issued only while `hold_empty` is 1. A write into a full holding register would overwrite the waiting character, and the flag relations assume no character is overwritten in that way. They also assume that `baud_x16` is a one-cycle pulse.

The stimulus keeps within these limits. It writes only after the reference model reports a free holding register. It places the second character of each pair while the first is still on the line, which exercises the back-to-back handoff. It generates ticks at irregular spacings of two and three clocks.

All 32 line-control settings are covered. Within each setting, the format input is scrambled after the last load, so that frame's shape must come from the captured copy.

// File: rtl/sft_pkg.sv
package sft_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_START  = 3'd1,
    PH_DATA   = 3'd2,
    PH_PARITY = 3'd3,
    PH_STOP   = 3'd4
  } phase_t;

  // bit order matches the line_ctrl port
  typedef struct packed {
    logic       par_even;
    logic       par_en;
    logic       long_stop;
    logic [1:0] len_code;
  } frame_cfg_t;

  function automatic int unsigned data_bits(input logic [1:0] len_code);
    return 32'd5 + 32'(len_code);
  endfunction

  // bit that makes data plus parity even (or odd) in ones
  function automatic logic parity_bit(input logic [7:0] data,
                                      input int unsigned nbits,
                                      input logic even);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < int'(nbits)) acc = acc ^ data[i];
    return even ? acc : ~acc;
  endfunction

  function automatic int unsigned stop_ticks(input frame_cfg_t cfg,
                                             input int unsigned tpb);
    if (!cfg.long_stop)       return tpb;
    if (cfg.len_code == 2'b00) return tpb + tpb / 2;
    return 2 * tpb;
  endfunction

endpackage

// File: rtl/sft_bit_timer.sv
module sft_bit_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  assign last = en && tick && (cnt == limit - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || !en) cnt <= '0;
    else if (tick)     cnt <= last ? '0 : cnt + CNT_W'(1);
  end
endmodule

// File: rtl/sft_hold_reg.sv
module sft_hold_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (wr) begin
      full <= 1'b1;
      data <= wdata;
    end else if (take) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/sft_shifter.sv
module sft_shifter
  import sft_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  frame_cfg_t        cfg_in,
  output logic              load_evt,
  output logic              txd,
  output logic              idle
);
  localparam int CNT_W = $clog2(2 * TICKS_PER_BIT + 1);
  localparam int IDX_W = $clog2(DATA_W);

  phase_t            ph;
  logic [DATA_W-1:0] sreg;
  frame_cfg_t        cfg_q;
  logic [IDX_W-1:0]  idx;
  logic              pbit;
  logic              last;
  logic [CNT_W-1:0]  limit;
  logic [IDX_W-1:0]  last_idx;

  assign idle     = (ph == PH_IDLE);
  assign load_evt = tick && idle && hold_full;
  assign limit    = (ph == PH_STOP) ? CNT_W'(stop_ticks(cfg_q, TICKS_PER_BIT))
                                    : CNT_W'(TICKS_PER_BIT);
  assign last_idx = IDX_W'(data_bits(cfg_q.len_code) - 1);

  sft_bit_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (!idle),
    .tick  (tick),
    .limit (limit),
    .last  (last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph    <= PH_IDLE;
      sreg  <= '0;
      cfg_q <= '0;
      idx   <= '0;
      pbit  <= 1'b0;
    end else if (load_evt) begin
      ph    <= PH_START;
      sreg  <= hold_data;
      cfg_q <= cfg_in;
      idx   <= '0;
      pbit  <= parity_bit(8'(hold_data), data_bits(cfg_in.len_code), cfg_in.par_even);
    end else if (last) begin
      case (ph)
        PH_START: begin
          ph  <= PH_DATA;
          idx <= '0;
        end
        PH_DATA: begin
          sreg <= sreg >> 1;
          if (idx == last_idx) ph <= cfg_q.par_en ? PH_PARITY : PH_STOP;
          else                 idx <= idx + IDX_W'(1);
        end
        PH_PARITY: ph <= PH_STOP;
        PH_STOP:   ph <= PH_IDLE;
        default:   ph <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    case (ph)
      PH_START:  txd = 1'b0;
      PH_DATA:   txd = sreg[0];
      PH_PARITY: txd = pbit;
      default:   txd = 1'b1;
    endcase
  end
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import sft_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_x16,
  input  logic              hold_wr,
  input  logic [DATA_W-1:0] hold_data,
  input  logic [4:0]        line_ctrl,
  output logic              txd,
  output logic              hold_empty,
  output logic              shift_empty
);
  logic              load_evt;
  logic              hold_full;
  logic [DATA_W-1:0] hold_q;
  frame_cfg_t        cfg_in;

  assign cfg_in     = frame_cfg_t'(line_ctrl);
  assign hold_empty = !hold_full;

  sft_hold_reg #(.DATA_W(DATA_W)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (hold_wr),
    .wdata (hold_data),
    .take  (load_evt),
    .full  (hold_full),
    .data  (hold_q)
  );

  sft_shifter #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (baud_x16),
    .hold_full (hold_full),
    .hold_data (hold_q),
    .cfg_in    (cfg_in),
    .load_evt  (load_evt),
    .txd       (txd),
    .idle      (shift_empty)
  );
endmodule

// File: rtl/sft_checker.sv
module sft_checker (
  input logic clk,
  input logic rst_n,
  input logic baud_x16,
  input logic hold_wr,
  input logic txd,
  input logic hold_empty,
  input logic shift_empty,
  input logic load_evt
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    shift_empty |-> txd); // R1

  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    hold_wr |=> !hold_empty); // R2

  AST_LOAD_FREES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !hold_wr) |=> hold_empty); // R2

  AST_LOAD_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (!txd && !shift_empty)); // R3

  AST_BUSY_ONLY_BY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shift_empty) |-> $past(load_evt)); // R10

  AST_QUIET_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!baud_x16 && !hold_wr) |=> ($stable(txd) && $stable(shift_empty) && $stable(hold_empty))); // R12
endmodule

bind serial_frame_tx sft_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .baud_x16    (baud_x16),
  .hold_wr     (hold_wr),
  .txd         (txd),
  .hold_empty  (hold_empty),
  .shift_empty (shift_empty),
  .load_evt    (load_evt)
);

// File: tb/test_serial_frame_tx.sv
module test_serial_frame_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_x16 = 1'b0;
  logic       hold_wr = 1'b0;
  logic [7:0] hold_data = '0;
  logic [4:0] line_ctrl = '0;
  logic       txd, hold_empty, shift_empty;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit done = 0;

  // reference model state
  bit    exp_q[$];
  string tag_q[$];
  bit    m_full = 0;
  bit    m_tick_seen = 0;
  bit    scrambled = 0;

  always #10 clk = ~clk;

  serial_frame_tx i_serial_frame_tx (
    .clk(clk), .rst_n(rst_n), .baud_x16(baud_x16), .hold_wr(hold_wr),
    .hold_data(hold_data), .line_ctrl(line_ctrl), .txd(txd),
    .hold_empty(hold_empty), .shift_empty(shift_empty)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", req, cycles, act, exp);
    end
  endtask

  task automatic push_bits(input bit v, input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(v);
      tag_q.push_back(tag);
    end
  endtask

  task automatic build_frame(input logic [7:0] d, input logic [4:0] lc);
    int nb, ones;
    bit p;
    nb = 5 + int'(lc[1:0]);
    ones = 0;
    push_bits(1'b0, 16, "R3");
    for (int i = 0; i < nb; i++) begin
      push_bits(d[i], 16, "R4");
      ones += int'(d[i]);
    end
    if (lc[3]) begin
      p = lc[4] ? bit'(ones % 2) : bit'(1 - ones % 2);
      push_bits(p, 16, "R5/R6");
    end
    if (!lc[2])      push_bits(1'b1, 16, "R7");
    else if (nb == 5) push_bits(1'b1, 24, "R8");
    else             push_bits(1'b1, 32, "R9");
  endtask

  logic [7:0] m_data;
  always @(posedge clk) begin
    bit loaded;
    loaded = 0;
    if (!rst_n) begin
      exp_q.delete();
      tag_q.delete();
      m_full = 0;
      m_tick_seen = 0;
    end else begin
      m_tick_seen = baud_x16;
      if (baud_x16) begin
        if (exp_q.size() > 0) begin
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
        end else if (m_full) begin
          build_frame(m_data, line_ctrl);
          loaded = 1;
        end
      end
      if (hold_wr) begin
        m_full = 1;
        m_data = hold_data;
      end else if (loaded) m_full = 0;
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    string t;
    if (rst_n && !done) begin
      if (!m_tick_seen)          t = "R12";
      else if (exp_q.size() > 0) t = tag_q[0];
      else                       t = "R10";
      if (scrambled) t = {t, "/R11"};
      chk(t, txd, exp_q.size() > 0 ? exp_q[0] : 1'b1);
      chk("R2", hold_empty, !m_full);
      chk("R10", shift_empty, exp_q.size() == 0);
    end
  end

  // irregular tick stream: gaps of 2 and 3 clocks
  initial begin
    int gap = 0;
    int sel = 0;
    forever begin
      @(negedge clk);
      if (gap == 0) begin
        baud_x16 = 1'b1;
        sel++;
        gap = (sel % 3 == 0) ? 2 : 1;
      end else begin
        baud_x16 = 1'b0;
        gap--;
      end
    end
  end

  task automatic write_char(input logic [7:0] d);
    while (m_full) @(negedge clk);
    hold_wr = 1'b1;
    hold_data = d;
    @(negedge clk);
    hold_wr = 1'b0;
    hold_data = 8'h00;
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        mismatched++;
        $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cycles);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", txd, 1'b1);
    chk("R1", hold_empty, 1'b1);
    chk("R1", shift_empty, 1'b1);
    for (int cfg = 0; cfg < 32; cfg++) begin
      line_ctrl = 5'(cfg);
      write_char(8'hA5 ^ 8'(cfg * 7));
      write_char(8'h3C + 8'(cfg * 11));   // written while the first is on the line
      while (m_full) @(negedge clk);
      @(negedge clk);
      // R11: format change during the frame must not take effect
      line_ctrl = ~5'(cfg);
      scrambled = 1;
      while (exp_q.size() > 0) @(negedge clk);
      scrambled = 0;
      line_ctrl = 5'(cfg);
      repeat (7) @(negedge clk);
    end
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule